// File: doc/BRIEF.md
# Quasi-Bidirectional Port Pin Controller

This block holds the digital control for a bank of quasi-bidirectional output pins. Each pin has a one-bit output latch and two drive enables that go to the pad: a pull-down enable and a strong pull-up enable. While a latch holds 0, its pin is pulled low. When a latch goes from 0 to 1, the strong pull-up is switched on for a fixed number of oscillator periods so that the pin charges quickly. After that pulse only the pad's weak keeper holds the pin high, and any external device can still pull the line low.

Each bank is configured through parameters. One parameter sets the number of pins and another sets the length of the strong pulse. The key-scan banks use 2 periods and the general-purpose group uses 1. A third parameter chooses what a read returns: the latch, the synchronized pin level, or either one per access, chosen by a select input. The synchronized pin level lets software see when an outside device holds the line low. The analog drivers, the resistors and the pad are outside this block.

Top module: `qbd_port`

## Requirements
- R1: In reset and in the first cycle after it, every latch reads 1, `strong_up_en` is all 0 and `pull_dn_en` is all 0.
- R2: While a pin's latch holds 0, its `pull_dn_en` bit is 1 and its `strong_up_en` bit is 0 in every cycle.
- R3: A write that takes a latch bit from 0 to 1 sets that pin's `strong_up_en` for exactly PULSE_LEN cycles, beginning in the cycle after the write edge.
- R4: Once the strong pulse has ended and while the latch holds 1, both drive enables of that pin are 0, so only the weak keeper acts.
- R5: Writing 1 to a pin whose latch already holds 1 does not start a new strong pulse.
- R6: Writing 0 to a pin during its strong pulse clears `strong_up_en` and sets `pull_dn_en` in the very next cycle.
- R7: `strong_up_en` and `pull_dn_en` are never both 1 on the same pin.
- R8: With READ_MODE = RD_LATCH, `rd_data` equals the latch contents whatever `pin_in` does.
- R9: With READ_MODE = RD_PIN, `rd_data` shows `pin_in` delayed by SYNC_STAGES clock edges.
- R10: With READ_MODE = RD_BY_ACCESS, `rd_data` is the latch when `rd_latch_sel` is 1 and the synchronized pin when it is 0.
- R11: Each pin runs its own pulse timer, so pins that rise in different cycles end their pulses in different cycles.
- R12: A bank built with PULSE_LEN = 1 keeps the strong pull-up on for one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; one period is one pulse unit |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the whole bank |
| wr_data | input | WIDTH | New latch value; bit i goes to pin i |
| pin_in | input | WIDTH | Level sensed on each pad |
| rd_latch_sel | input | 1 | In RD_BY_ACCESS mode, 1 reads the latch and 0 reads the pin |
| rd_data | output | WIDTH | Read result |
| pull_dn_en | output | WIDTH | Per-pin pull-down drive enable |
| strong_up_en | output | WIDTH | Per-pin strong pull-up drive enable |

## Verification
The hardest case to reach is a falling write that arrives in the middle of a strong pulse. To create it, the bench first writes a rising value and then writes 0 on the very next negative edge, while the timer is still loaded. The bench also staggers rises on two pins by one cycle, so that overlapping timers, each at a different count, are checked in the same cycle. Three banks with pulse lengths 2, 1 and 3 share one write stream, so a single sequence covers every pulse length and every read mode.

// File: rtl/qbd_pkg.sv
package qbd_pkg;

  typedef enum logic [1:0] {
    RD_LATCH     = 2'd0,
    RD_PIN       = 2'd1,
    RD_BY_ACCESS = 2'd2
  } qbd_rd_mode_e;

  // width of a down-counter that must hold the value len
  function automatic int unsigned qbd_cnt_width(input int unsigned len);
    return (len < 2) ? 1 : $clog2(len + 1);
  endfunction

  // a latch bit rises when a write stores 1 over a stored 0
  function automatic logic qbd_is_rise(input logic wr, input logic d, input logic q);
    return wr & d & ~q;
  endfunction

endpackage

// File: rtl/qbd_pin_cell.sv
module qbd_pin_cell #(
  parameter int unsigned PULSE_LEN = 2,
  parameter int unsigned CW        = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_bit,
  output logic latch_q,
  output logic strong_q,
  output logic rise_evt
);
  import qbd_pkg::*;

  localparam logic [CW-1:0] LOAD = CW'(PULSE_LEN);

  logic [CW-1:0] cnt_q;

  assign rise_evt = qbd_is_rise(wr_en, wr_bit, latch_q);
  assign strong_q = (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= 1'b1;
      cnt_q   <= '0;
    end else begin
      if (wr_en) latch_q <= wr_bit;
      if (rise_evt)
        cnt_q <= LOAD;
      else if (wr_en && !wr_bit)
        cnt_q <= '0;
      else if (cnt_q != '0)
        cnt_q <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/qbd_pin_sync.sv
module qbd_pin_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_sync
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign pin_sync = pin_in;
    end else begin : g_chain
      logic [WIDTH-1:0] stage_q [STAGES];
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int s = 0; s < STAGES; s++) stage_q[s] <= '1;
        end else begin
          stage_q[0] <= pin_in;
          for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
      end
      assign pin_sync = stage_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/qbd_read_mux.sv
module qbd_read_mux #(
  parameter int unsigned          WIDTH     = 8,
  parameter qbd_pkg::qbd_rd_mode_e READ_MODE = qbd_pkg::RD_LATCH
) (
  input  logic [WIDTH-1:0] latch_v,
  input  logic [WIDTH-1:0] pin_v,
  input  logic             sel_latch,
  output logic [WIDTH-1:0] rd_v
);
  generate
    if (READ_MODE == qbd_pkg::RD_LATCH) begin : g_latch
      assign rd_v = latch_v;
    end else if (READ_MODE == qbd_pkg::RD_PIN) begin : g_pin
      assign rd_v = pin_v;
    end else begin : g_access
      assign rd_v = sel_latch ? latch_v : pin_v;
    end
  endgenerate

  logic unused_ok;
  assign unused_ok = ^{sel_latch, latch_v, pin_v};
endmodule

// File: rtl/qbd_port.sv
module qbd_port #(
  parameter int unsigned           WIDTH       = 8,
  parameter int unsigned           PULSE_LEN   = 2,
  parameter int unsigned           SYNC_STAGES = 2,
  parameter qbd_pkg::qbd_rd_mode_e READ_MODE   = qbd_pkg::RD_LATCH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [WIDTH-1:0] pin_in,
  input  logic             rd_latch_sel,
  output logic [WIDTH-1:0] rd_data,
  output logic [WIDTH-1:0] pull_dn_en,
  output logic [WIDTH-1:0] strong_up_en
);
  localparam int unsigned CW = qbd_pkg::qbd_cnt_width(PULSE_LEN);

  logic [WIDTH-1:0] latch_v;
  logic [WIDTH-1:0] rise_evt;
  logic [WIDTH-1:0] pin_sync;

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    qbd_pin_cell #(.PULSE_LEN(PULSE_LEN), .CW(CW)) u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_bit   (wr_data[i]),
      .latch_q  (latch_v[i]),
      .strong_q (strong_up_en[i]),
      .rise_evt (rise_evt[i])
    );
  end

  assign pull_dn_en = ~latch_v;

  qbd_pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_in   (pin_in),
    .pin_sync (pin_sync)
  );

  qbd_read_mux #(.WIDTH(WIDTH), .READ_MODE(READ_MODE)) u_rd (
    .latch_v   (latch_v),
    .pin_v     (pin_sync),
    .sel_latch (rd_latch_sel),
    .rd_v      (rd_data)
  );

endmodule

// File: rtl/qbd_port_chk.sv
module qbd_port_chk #(
  parameter int unsigned           WIDTH     = 8,
  parameter int unsigned           PULSE_LEN = 2,
  parameter qbd_pkg::qbd_rd_mode_e READ_MODE = qbd_pkg::RD_LATCH
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [WIDTH-1:0] wr_data,
  input logic [WIDTH-1:0] rd_data,
  input logic [WIDTH-1:0] pull_dn_en,
  input logic [WIDTH-1:0] strong_up_en,
  input logic [WIDTH-1:0] rise_evt
);
  localparam int unsigned RW = qbd_pkg::qbd_cnt_width(PULSE_LEN) + 1;

  assert_no_contention_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strong_up_en & pull_dn_en) == '0);

  assert_rise_starts_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt != '0) |=> ((strong_up_en & $past(rise_evt)) == $past(rise_evt)));

  assert_low_write_pulls_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((pull_dn_en == ~$past(wr_data)) && ((strong_up_en & pull_dn_en) == '0)));

  assert_no_repulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((strong_up_en & $past(wr_data & ~pull_dn_en & ~strong_up_en)) == '0));

  for (genvar i = 0; i < WIDTH; i++) begin : g_run
    logic [RW-1:0] run_q;
    always_ff @(posedge clk) begin
      if (!rst_n)               run_q <= '0;
      else if (!strong_up_en[i]) run_q <= '0;
      else if (run_q != '1)      run_q <= run_q + 1'b1;
    end
    assert_pulse_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= RW'(PULSE_LEN));
  end

  if (READ_MODE == qbd_pkg::RD_LATCH) begin : g_latch_rd
    assert_latch_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data == ~pull_dn_en);
  end
endmodule

bind qbd_port qbd_port_chk #(
  .WIDTH(WIDTH), .PULSE_LEN(PULSE_LEN), .READ_MODE(READ_MODE)
) u_qbd_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .wr_data      (wr_data),
  .rd_data      (rd_data),
  .pull_dn_en   (pull_dn_en),
  .strong_up_en (strong_up_en),
  .rise_evt     (rise_evt)
);

// File: tb/test_qbd_port.sv
module test_qbd_port;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] pin_in = 8'h3C;
  logic         rd_latch_sel = 1'b1;

  logic [W-1:0] rd_a, pd_a, su_a;
  logic [W-1:0] rd_b, pd_b, su_b;
  logic [W-1:0] rd_c, pd_c, su_c;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  // key-scan style bank: 2-period pulse, reads the latch
  qbd_port #(.WIDTH(W), .PULSE_LEN(2), .SYNC_STAGES(2), .READ_MODE(qbd_pkg::RD_LATCH)) i_qbd_port (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .pin_in(pin_in),
    .rd_latch_sel(rd_latch_sel), .rd_data(rd_a), .pull_dn_en(pd_a), .strong_up_en(su_a));

  // general-purpose style bank: 1-period pulse, reads the pin
  qbd_port #(.WIDTH(W), .PULSE_LEN(1), .SYNC_STAGES(2), .READ_MODE(qbd_pkg::RD_PIN)) i_qbd_port_gp (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .pin_in(pin_in),
    .rd_latch_sel(rd_latch_sel), .rd_data(rd_b), .pull_dn_en(pd_b), .strong_up_en(su_b));

  // dual-path bank: 3-period pulse, read source chosen per access
  qbd_port #(.WIDTH(W), .PULSE_LEN(3), .SYNC_STAGES(2), .READ_MODE(qbd_pkg::RD_BY_ACCESS)) i_qbd_port_acc (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .pin_in(pin_in),
    .rd_latch_sel(rd_latch_sel), .rd_data(rd_c), .pull_dn_en(pd_c), .strong_up_en(su_c));

  task automatic chk(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // called on a negedge; returns on the next negedge, after the write edge
  task automatic do_write(input logic [W-1:0] d);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "latch in reset", rd_a, 8'hFF);
    chk("R1", "strong in reset", su_a, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "latch after reset", rd_a, 8'hFF);
    chk("R1", "strong after reset", su_a | su_b | su_c, 8'h00);
    chk("R1", "pull-down after reset", pd_a | pd_b | pd_c, 8'h00);
  endtask

  task automatic t_write_low;
    do_write(8'h0F);
    for (int k = 0; k < 3; k++) begin
      chk("R2", "pull-down while low", pd_a, 8'hF0);
      chk("R2", "strong while low", su_a, 8'h00);
      @(negedge clk);
    end
    chk("R8", "latch read", rd_a, 8'h0F);
  endtask

  task automatic t_pulse;
    do_write(8'hFF);
    chk("R3", "2-period pulse cycle 1", su_a, 8'hF0);
    chk("R12", "1-period pulse cycle 1", su_b, 8'hF0);
    chk("R3", "3-period pulse cycle 1", su_c, 8'hF0);
    chk("R2", "pull-down released", pd_a, 8'h00);
    @(negedge clk);
    chk("R3", "2-period pulse cycle 2", su_a, 8'hF0);
    chk("R12", "1-period pulse over", su_b, 8'h00);
    @(negedge clk);
    chk("R3", "2-period pulse over", su_a, 8'h00);
    chk("R3", "3-period pulse cycle 3", su_c, 8'hF0);
    chk("R4", "keeper only", su_a | pd_a, 8'h00);
    @(negedge clk);
    chk("R3", "3-period pulse over", su_c, 8'h00);
  endtask

  task automatic t_no_repulse;
    do_write(8'hFF);
    chk("R5", "no pulse on 1 over 1", su_a | su_b | su_c, 8'h00);
    @(negedge clk);
    chk("R5", "still no pulse", su_a, 8'h00);
  endtask

  task automatic t_cut;
    do_write(8'h00);
    chk("R2", "all low", pd_a, 8'hFF);
    do_write(8'hFF);
    chk("R3", "pulse started", su_a, 8'hFF);
    do_write(8'h00);
    chk("R6", "pulse cut", su_a | su_c, 8'h00);
    chk("R6", "pull-down after cut", pd_a, 8'hFF);
    @(negedge clk);
    chk("R6", "stays cut", su_a, 8'h00);
  endtask

  task automatic t_independent;
    do_write(8'h01);
    chk("R11", "pin0 first cycle", su_a, 8'h01);
    do_write(8'h03);
    chk("R11", "overlapping timers", su_a, 8'h03);
    @(negedge clk);
    chk("R11", "pin0 done, pin1 running", su_a, 8'h02);
    @(negedge clk);
    chk("R11", "both done", su_a, 8'h00);
  endtask

  task automatic t_reads;
    pin_in = 8'hA5;
    @(negedge clk);
    chk("R9", "pin read one edge late", rd_b, 8'h3C);
    @(negedge clk);
    chk("R9", "pin read after two edges", rd_b, 8'hA5);
    chk("R8", "latch read ignores pin", rd_a, 8'h03);
    rd_latch_sel = 1'b1;
    #1;
    chk("R10", "access read latch", rd_c, 8'h03);
    rd_latch_sel = 1'b0;
    #1;
    chk("R10", "access read pin", rd_c, 8'hA5);
    rd_latch_sel = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_write_low();
    t_pulse();
    t_no_repulse();
    t_cut();
    t_independent();
    t_reads();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule